// File: doc/BRIEF.md
# I2S Slave Receive Buffer, Status Flags and Interrupt Request

This block sits between the serial deserializer of a slave-mode serial audio port and the register file that software reads. It keeps the last received audio word, tracks five status flags and drives one level-sensitive interrupt request. The flags are receive-not-empty, transmit-empty, underrun, overrun and frame error. The shifter reports each event to the block with a one-cycle strobe: a word was captured, the transmit holding register was taken, or WS moved at a bit position where no transition belongs. Register access appears as one-cycle strobes for a data read, a data write and a status read.

Reception is gated by a word-select synchronisation state. The first condition is that the interface is enabled. The second is that WS has been seen at the idle level of the selected audio standard. A frame error drops this state, and no word is taken again until WS returns to the idle level.

After an overrun the receive buffer keeps the last good word. It stays frozen until software completes the clear sequence. No checksum logic is involved in this mode.

Top module: `i2s_slave_status`

## Requirements
- R1: A word strobe accepted while receive-not-empty is set and no data read occurs in the same cycle sets overrun (status bit 3) on the next cycle. That word is discarded.
- R2: While overrun is set, the receive buffer and read data keep the last good word. Every word that arrives is discarded and does not set receive-not-empty.
- R3: Overrun clears only when a data read is followed, in a later cycle, by a status read. A status read alone, a data read alone, or a status read before the data read leaves it set.
- R4: Frame error (status bit 4) is set only in slave mode, by a WS-error strobe while reception is active. Such a strobe also drops the active state.
- R5: Reception is active only after the enable input is high and WS has been sampled at the idle level of the standard. Standard code 0 (Philips) idles high. Codes 1 (MSB-justified), 2 (LSB-justified) and 3 (PCM) idle low. Disabling drops the active state in the next cycle. While the block is inactive, word and WS-error strobes are ignored.
- R6: Frame error and underrun clear on a status read.
- R7: Receive-not-empty (status bit 0) is set when a word is captured and is cleared by a data read. Transmit-empty (status bit 1) is set when the holding register is taken and is cleared by a data write.
- R8: Underrun (status bit 2) is set when the holding register is taken while transmit-empty is still set, in slave mode with reception active.
- R9: The interrupt output is high exactly while at least one enabled flag is set. Receive-not-empty has its own enable and so does transmit-empty. Overrun, underrun and frame error share one error enable.
- R10: A flag-setting event and a clearing access in the same cycle leave the flag set.
- R11: After reset the status word is 5'b00010 (only transmit-empty set), the read data is zero and reception is inactive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| enable | input | 1 | Interface enable |
| slave | input | 1 | High when the interface runs as a slave |
| std_sel | input | 2 | Audio standard: 0 Philips, 1 MSB-justified, 2 LSB-justified, 3 PCM |
| ws | input | 1 | Current WS level |
| ws_err | input | 1 | Strobe: WS moved at an unexpected bit position |
| rx_valid | input | 1 | Strobe: deserializer has a complete word |
| rx_data | input | DW | Received word |
| tx_take | input | 1 | Strobe: shifter takes the transmit holding register |
| dr_wr | input | 1 | Strobe: data register write |
| dr_rd | input | 1 | Strobe: data register read |
| sr_rd | input | 1 | Strobe: status register read |
| ie_rxne | input | 1 | Interrupt enable, receive-not-empty |
| ie_txe | input | 1 | Interrupt enable, transmit-empty |
| ie_err | input | 1 | Shared interrupt enable for overrun, underrun, frame error |
| rd_data | output | DW | Receive buffer contents |
| status | output | 5 | {frame error, overrun, underrun, transmit-empty, receive-not-empty} |
| rx_active | output | 1 | Reception synchronised and active |
| irq | output | 1 | Level interrupt request |

## Verification
The bench drives the overrun clear sequence in both orders and with each read alone. A design that clears on a single read, or that accepts the reads in either order, loses overrun early. Words sent during overrun are checked to leave the buffer and receive-not-empty unchanged, so a buffer that is not frozen shows the newer word. Resynchronisation is tested with the idle WS level of each standard, after a frame error and after a disable. Same-cycle set and clear collisions are also tested: if the clear wins, the flag drops when it should stay high.

// File: rtl/i2s_stat_pkg.sv
package i2s_stat_pkg;
  typedef enum logic [1:0] {
    STD_PHILIPS = 2'd0,
    STD_MSB     = 2'd1,
    STD_LSB     = 2'd2,
    STD_PCM     = 2'd3
  } std_e;

  localparam int FL_RXNE = 0;
  localparam int FL_TXE  = 1;
  localparam int FL_UDR  = 2;
  localparam int FL_OVR  = 3;
  localparam int FL_FRE  = 4;
  localparam int NFLAG   = 5;

  function automatic logic idle_ws(std_e s);
    return (s == STD_PHILIPS);
  endfunction
endpackage

// File: rtl/i2s_rst_sync.sv
module i2s_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_q = chain_q[STAGES-1];
endmodule

// File: rtl/i2s_ws_sync.sv
module i2s_ws_sync
  import i2s_stat_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  input  logic slave,
  input  std_e std_sel,
  input  logic ws,
  input  logic ws_err,
  input  logic sr_rd,
  output logic gate,
  output logic fre_set,
  output logic active,
  output logic fre
);
  logic active_d, fre_d;

  assign gate    = active & enable;
  assign fre_set = gate & slave & ws_err;

  always_comb begin
    active_d = active;
    if (!enable)                          active_d = 1'b0;
    else if (fre_set)                     active_d = 1'b0;
    else if (!active && (ws == idle_ws(std_sel))) active_d = 1'b1;
    fre_d = fre;
    if (fre_set)    fre_d = 1'b1;
    else if (sr_rd) fre_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      fre    <= 1'b0;
    end else begin
      active <= active_d;
      fre    <= fre_d;
    end
  end
endmodule

// File: rtl/i2s_rx_buffer.sv
module i2s_rx_buffer #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          gate,
  input  logic          rx_valid,
  input  logic [DW-1:0] rx_data,
  input  logic          dr_rd,
  input  logic          sr_rd,
  output logic          rxne,
  output logic          ovr,
  output logic [DW-1:0] rd_data
);
  logic accept, capture, ovr_set, ovr_clr;
  logic rxne_d, ovr_d, seen_q, seen_d;

  assign accept  = gate & rx_valid;
  assign capture = accept & ~ovr & (~rxne | dr_rd);
  assign ovr_set = accept & ~ovr & rxne & ~dr_rd;
  assign ovr_clr = ovr & sr_rd & seen_q;

  always_comb begin
    rxne_d = rxne;
    if (capture)    rxne_d = 1'b1;
    else if (dr_rd) rxne_d = 1'b0;
    ovr_d  = ovr;
    seen_d = seen_q;
    if (ovr_set) begin
      ovr_d  = 1'b1;
      seen_d = 1'b0;
    end else if (ovr_clr) begin
      ovr_d  = 1'b0;
      seen_d = 1'b0;
    end else if (ovr && dr_rd) begin
      seen_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rxne   <= 1'b0;
      ovr    <= 1'b0;
      seen_q <= 1'b0;
    end else begin
      rxne   <= rxne_d;
      ovr    <= ovr_d;
      seen_q <= seen_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       rd_data <= '0;
    else if (capture) rd_data <= rx_data;
  end
endmodule

// File: rtl/i2s_tx_flags.sv
module i2s_tx_flags (
  input  logic clk,
  input  logic rst_n,
  input  logic gate,
  input  logic slave,
  input  logic tx_take,
  input  logic dr_wr,
  input  logic sr_rd,
  output logic txe,
  output logic udr
);
  logic txe_d, udr_d, udr_set;

  assign udr_set = tx_take & txe & slave & gate;

  always_comb begin
    txe_d = txe;
    if (tx_take)    txe_d = 1'b1;
    else if (dr_wr) txe_d = 1'b0;
    udr_d = udr;
    if (udr_set)    udr_d = 1'b1;
    else if (sr_rd) udr_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      txe <= 1'b1;
      udr <= 1'b0;
    end else begin
      txe <= txe_d;
      udr <= udr_d;
    end
  end
endmodule

// File: rtl/i2s_irq_comb.sv
module i2s_irq_comb #(
  parameter int N = 5
) (
  input  logic [N-1:0] flags,
  input  logic [N-1:0] mask,
  output logic         irq
);
  logic [N-1:0] hit;
  for (genvar i = 0; i < N; i++) begin : g_src
    assign hit[i] = flags[i] & mask[i];
  end
  assign irq = |hit;
endmodule

// File: rtl/i2s_slave_status.sv
module i2s_slave_status
  import i2s_stat_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          enable,
  input  logic          slave,
  input  logic [1:0]    std_sel,
  input  logic          ws,
  input  logic          ws_err,
  input  logic          rx_valid,
  input  logic [DW-1:0] rx_data,
  input  logic          tx_take,
  input  logic          dr_wr,
  input  logic          dr_rd,
  input  logic          sr_rd,
  input  logic          ie_rxne,
  input  logic          ie_txe,
  input  logic          ie_err,
  output logic [DW-1:0] rd_data,
  output logic [NFLAG-1:0] status,
  output logic          rx_active,
  output logic          irq
);
  logic rst_q, gate, fre_set;
  logic rxne, ovr, txe, udr, fre;
  logic [NFLAG-1:0] irq_mask;

  i2s_rst_sync #(.STAGES(2)) u_rst (.clk(clk), .rst_n(rst_n), .rst_q(rst_q));

  i2s_ws_sync u_ws (
    .clk(clk), .rst_n(rst_q), .enable(enable), .slave(slave),
    .std_sel(std_e'(std_sel)), .ws(ws), .ws_err(ws_err), .sr_rd(sr_rd),
    .gate(gate), .fre_set(fre_set), .active(rx_active), .fre(fre)
  );

  i2s_rx_buffer #(.DW(DW)) u_rx (
    .clk(clk), .rst_n(rst_q), .gate(gate), .rx_valid(rx_valid),
    .rx_data(rx_data), .dr_rd(dr_rd), .sr_rd(sr_rd),
    .rxne(rxne), .ovr(ovr), .rd_data(rd_data)
  );

  i2s_tx_flags u_tx (
    .clk(clk), .rst_n(rst_q), .gate(gate), .slave(slave),
    .tx_take(tx_take), .dr_wr(dr_wr), .sr_rd(sr_rd), .txe(txe), .udr(udr)
  );

  always_comb begin
    status          = '0;
    status[FL_RXNE] = rxne;
    status[FL_TXE]  = txe;
    status[FL_UDR]  = udr;
    status[FL_OVR]  = ovr;
    status[FL_FRE]  = fre;
    irq_mask          = '0;
    irq_mask[FL_RXNE] = ie_rxne;
    irq_mask[FL_TXE]  = ie_txe;
    irq_mask[FL_UDR]  = ie_err;
    irq_mask[FL_OVR]  = ie_err;
    irq_mask[FL_FRE]  = ie_err;
  end

  i2s_irq_comb #(.N(NFLAG)) u_irq (.flags(status), .mask(irq_mask), .irq(irq));
endmodule

// File: rtl/i2s_slave_status_chk.sv
module i2s_slave_status_chk #(
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst_q,
  input logic          gate,
  input logic          enable,
  input logic          slave,
  input logic [1:0]    std_sel,
  input logic          ws,
  input logic          ws_err,
  input logic          rx_valid,
  input logic          dr_rd,
  input logic          sr_rd,
  input logic          ie_rxne,
  input logic          ie_txe,
  input logic          ie_err,
  input logic [DW-1:0] rd_data,
  input logic [4:0]    status,
  input logic          rx_active,
  input logic          irq
);
  // R1
  a_r1_ovr_set: assert property (@(posedge clk) disable iff (!rst_q)
    gate && rx_valid && status[0] && !dr_rd && !status[3] |=> status[3]);
  // R2
  a_r2_frozen: assert property (@(posedge clk) disable iff (!rst_q)
    status[3] |=> $stable(rd_data));
  // R3
  a_r3_no_lone_clear: assert property (@(posedge clk) disable iff (!rst_q)
    status[3] && !sr_rd |=> status[3]);
  // R4
  a_r4_master_no_fre: assert property (@(posedge clk) disable iff (!rst_q)
    !slave && !status[4] |=> !status[4]);
  // R5
  a_r5_arm_level: assert property (@(posedge clk) disable iff (!rst_q)
    !rx_active && enable && (ws != (std_sel == 2'd0)) |=> !rx_active);
  // R6
  a_r6_fre_clear: assert property (@(posedge clk) disable iff (!rst_q)
    status[4] && sr_rd && !(gate && slave && ws_err) |=> !status[4]);
  // R9
  a_r9_irq_masked: assert property (@(posedge clk) disable iff (!rst_q)
    !ie_rxne && !ie_txe && !ie_err |-> !irq);
  a_r9_irq_err: assert property (@(posedge clk) disable iff (!rst_q)
    ie_err && (status[2] || status[3] || status[4]) |-> irq);
endmodule

bind i2s_slave_status i2s_slave_status_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_q(rst_q), .gate(gate), .enable(enable), .slave(slave),
  .std_sel(std_sel), .ws(ws), .ws_err(ws_err), .rx_valid(rx_valid),
  .dr_rd(dr_rd), .sr_rd(sr_rd), .ie_rxne(ie_rxne), .ie_txe(ie_txe),
  .ie_err(ie_err), .rd_data(rd_data), .status(status),
  .rx_active(rx_active), .irq(irq)
);

// File: tb/sim_i2s_slave_status.sv
module sim_i2s_slave_status;
  localparam int DW = 16;
  logic clk = 1'b0;
  logic rst_n;
  logic enable, slave, ws, ws_err, rx_valid, tx_take, dr_wr, dr_rd, sr_rd;
  logic ie_rxne, ie_txe, ie_err;
  logic [1:0] std_sel;
  logic [DW-1:0] rx_data, rd_data;
  logic [4:0] status;
  logic rx_active, irq;

  int checks = 0, errors = 0;
  bit done = 0;

  // bench reference state
  logic m_rxne, m_txe, m_udr, m_ovr, m_fre, m_act, m_seen;
  logic [DW-1:0] m_buf;

  always #10 clk = ~clk;

  i2s_slave_status #(.DW(DW)) u0 (
    .clk(clk), .rst_n(rst_n), .enable(enable), .slave(slave), .std_sel(std_sel),
    .ws(ws), .ws_err(ws_err), .rx_valid(rx_valid), .rx_data(rx_data),
    .tx_take(tx_take), .dr_wr(dr_wr), .dr_rd(dr_rd), .sr_rd(sr_rd),
    .ie_rxne(ie_rxne), .ie_txe(ie_txe), .ie_err(ie_err),
    .rd_data(rd_data), .status(status), .rx_active(rx_active), .irq(irq)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic exp_irq();
    return (m_rxne & ie_rxne) | (m_txe & ie_txe) | (ie_err & (m_ovr | m_udr | m_fre));
  endfunction

  task automatic model_step();
    logic g, acc, cap, oset, oclr, fset, uset;
    g    = m_act & enable;
    acc  = g & rx_valid;
    cap  = acc & !m_ovr & (!m_rxne | dr_rd);
    oset = acc & !m_ovr & m_rxne & !dr_rd;
    oclr = m_ovr & sr_rd & m_seen;
    fset = g & slave & ws_err;
    uset = tx_take & m_txe & slave & g;
    if (cap) m_buf = rx_data;
    m_seen = (m_ovr && !oclr) ? (m_seen | dr_rd) : 1'b0;
    m_ovr  = oset | (m_ovr & !oclr);
    m_rxne = cap | (m_rxne & !dr_rd);
    m_udr  = uset | (m_udr & !sr_rd);
    m_txe  = tx_take | (m_txe & !dr_wr);
    m_fre  = fset | (m_fre & !sr_rd);
    if (!enable || fset) m_act = 1'b0;
    else if (!m_act) m_act = (ws == (std_sel == 2'd0));
  endtask

  task automatic compare();
    chk("R7 rxne", status[0], m_rxne);
    chk("R7 txe", status[1], m_txe);
    chk("R8 udr", status[2], m_udr);
    chk("R1 ovr", status[3], m_ovr);
    chk("R4 fre", status[4], m_fre);
    chk("R5 active", rx_active, m_act);
    chk("R2 rd_data", rd_data, m_buf);
    chk("R9 irq", irq, exp_irq());
  endtask

  task automatic tick();
    @(posedge clk);
    model_step();
    @(negedge clk);
    compare();
    rx_valid = 0; ws_err = 0; tx_take = 0; dr_wr = 0; dr_rd = 0; sr_rd = 0;
  endtask

  initial begin
    #4000000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    rst_n = 0; enable = 0; slave = 1; std_sel = 2'd0; ws = 0;
    rx_valid = 0; ws_err = 0; tx_take = 0; dr_wr = 0; dr_rd = 0; sr_rd = 0;
    rx_data = '0; ie_rxne = 0; ie_txe = 0; ie_err = 0;
    m_rxne = 0; m_txe = 1; m_udr = 0; m_ovr = 0; m_fre = 0; m_act = 0; m_seen = 0;
    m_buf = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R11 status", status, 5'b00010);
    chk("R11 rd_data", rd_data, 0);
    chk("R11 active", rx_active, 0);

    // R5 Philips idles high
    enable = 1; ws = 0; tick(); chk("R5 philips low", rx_active, 0);
    ws = 1; tick(); chk("R5 philips high", rx_active, 1);

    // R1 R2 R3 overrun sequence
    rx_valid = 1; rx_data = 16'hA001; tick(); chk("R7 capture", status[0], 1);
    rx_valid = 1; rx_data = 16'hB002; tick(); chk("R1 ovr set", status[3], 1);
    chk("R1 keeps old", rd_data, 16'hA001);
    rx_valid = 1; rx_data = 16'hC003; tick(); chk("R2 frozen", rd_data, 16'hA001);
    sr_rd = 1; tick(); chk("R3 sr first", status[3], 1);
    dr_rd = 1; tick(); chk("R3 dr only", status[3], 1);
    chk("R7 rxne read", status[0], 0);
    rx_valid = 1; rx_data = 16'hD004; tick(); chk("R2 discarded", status[0], 0);
    chk("R2 data kept", rd_data, 16'hA001);
    sr_rd = 1; tick(); chk("R3 cleared", status[3], 0);
    rx_valid = 1; rx_data = 16'hE005; tick(); chk("R7 new word", rd_data, 16'hE005);

    // R10 capture with read in same cycle
    dr_rd = 1; rx_valid = 1; rx_data = 16'hF006; tick();
    chk("R10 rxne stays", status[0], 1); chk("R10 no ovr", status[3], 0);
    dr_rd = 1; tick();

    // R4 R6 frame error and resync
    ws_err = 1; tick(); chk("R4 fre set", status[4], 1); chk("R4 drop", rx_active, 0);
    rx_valid = 1; rx_data = 16'h1111; tick(); chk("R5 ignored inactive", status[0], 0);
    chk("R5 resynced", rx_active, 1);
    sr_rd = 1; tick(); chk("R6 fre clear", status[4], 0);
    slave = 0; ws_err = 1; tick(); chk("R4 master", status[4], 0);
    slave = 1;

    // R5 PCM idles low, disable drops
    std_sel = 2'd3; enable = 0; tick(); chk("R5 disabled", rx_active, 0);
    enable = 1; ws = 1; tick(); chk("R5 pcm high", rx_active, 0);
    ws = 0; tick(); chk("R5 pcm low", rx_active, 1);

    // R8 R10 R6 underrun
    tx_take = 1; tick(); chk("R8 udr", status[2], 1);
    tx_take = 1; sr_rd = 1; tick(); chk("R10 udr stays", status[2], 1);
    sr_rd = 1; tick(); chk("R6 udr clear", status[2], 0);
    dr_wr = 1; tick(); chk("R7 txe clear", status[1], 0);
    tx_take = 1; tick(); chk("R7 txe set", status[1], 1); chk("R8 loaded", status[2], 0);

    // R9 interrupt mapping
    ie_txe = 1; tick(); chk("R9 txe irq", irq, 1);
    ie_txe = 0; tick(); chk("R9 masked", irq, 0);
    ie_err = 1; ws_err = 1; tick(); chk("R9 err irq", irq, 1);
    sr_rd = 1; tick(); chk("R9 err gone", irq, 0);

    // random phase
    for (int i = 0; i < 4000; i++) begin
      enable   = ($urandom % 25) != 0;
      slave    = ($urandom % 12) != 0;
      if ($urandom % 8 == 0) ws = ~ws;
      if ($urandom % 200 == 0) std_sel = 2'($urandom);
      rx_valid = ($urandom % 4) == 0;
      rx_data  = 16'($urandom);
      ws_err   = ($urandom % 50) == 0;
      dr_rd    = ($urandom % 5) == 0;
      sr_rd    = ($urandom % 5) == 0;
      dr_wr    = ($urandom % 4) == 0;
      tx_take  = ($urandom % 6) == 0;
      if ($urandom % 16 == 0) {ie_rxne, ie_txe, ie_err} = 3'($urandom);
      tick();
    end

    done = 1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule